// File: doc/BRIEF.md
# Extended Capability Control and Test FIFO Register Block

This block is the extended-capability register window of a parallel port. It has eight byte locations. A host reads and writes them one byte at a time through a simple strobe interface. The most important location is the extended control register. Its upper three bits choose the port's operating mode. Its lowest two bits report the state of a small byte FIFO, and the host cannot write them. There are also two configuration bytes that the host can read and write. Offset 0 has two roles. In the FIFO test mode it is the FIFO data port. In every other mode it is configuration byte A.

The FIFO can only be reached from the host while the mode is FIFO test. In that mode, each write to offset 0 pushes one byte and each read of offset 0 pops one byte. Whenever the mode field changes, the FIFO is flushed. The flag encoding is taken from the pointer positions and not from an occupancy count. The full flag is raised when the write pointer wraps past the last entry. The empty flag is raised when a pop makes the read pointer equal to the write pointer. A read of offset 0 has its side effect (the pop) on the clock edge that ends the access cycle. The byte returned is the one presented combinationally during that cycle.

Top module: `ecp_ext_ctrl`

## Requirements
- R1: After reset the control register reads 0x01 (mode 000 compatibility, status empty). Configuration bytes A and B both read 0x00.
- R2: Control register bits 1:0 hold the FIFO status. 01 means empty, 10 means full and 00 means holding data. The value 11 never appears.
- R3: A write to offset 2 replaces the mode field (bits 7:5) and stores bits 4:2. Bits 1:0 of the written byte are ignored. If the mode is unchanged, the status bits keep their value.
- R4: A write to offset 2 whose bits 7:5 differ from the current mode flushes the FIFO. Both pointers return to entry 0 and the status becomes empty (01).
- R5: In FIFO test mode (mode 110), a write to offset 0 pushes the byte. The status becomes 00, or 10 when the write pointer wraps past the last of the DEPTH entries (default 2).
- R6: In FIFO test mode, a read of offset 0 returns the byte at the read pointer and then advances that pointer with wraparound. The status becomes 01 if the read pointer then equals the write pointer, and 00 otherwise. Bytes come out in the order they were pushed.
- R7: A push while the status is full (10) is dropped. The status and the stored bytes do not change.
- R8: A pop while the status is empty (01) returns the byte at the read pointer. The pointers and the status do not change.
- R9: In any mode other than 110, offset 0 is configuration byte A, which can be read and written. Accesses to it leave the FIFO status unchanged.
- R10: Offset 1 is configuration byte B, which can be read and written in every mode.
- R11: Offsets 3 to 7 read 0xFF, and writes to them change no readable state.
- R12: When wr_en and rd_en are both high in the same cycle, only the write takes effect. A read of offset 0 in that cycle does not pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe for the current cycle |
| rd_en | input | 1 | Byte read strobe; the pop side effect happens at the cycle's closing edge |
| addr | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for the addressed offset |

## Verification
The assertions check on every cycle that the status code is never 11 and that a mode-changing control write always leaves the status empty. They also check that the status holds when the mode is rewritten with its own value, and that it does not move in non-test modes. Full-push drops, empty-pop holds and the all-ones value of the unused offsets are checked on every cycle as well. Only the bench scenarios can show that bytes leave in push order and that a flush rewinds the read pointer, which shows up as a stale entry returned by the next empty pop. The bench scenarios also cover the split role of offset 0 and the priority of a write over a read in the same cycle.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    MODE_COMPAT  = 3'd0,
    MODE_BYTE    = 3'd1,
    MODE_PPFIFO  = 3'd2,
    MODE_ECPFIFO = 3'd3,
    MODE_EPP     = 3'd4,
    MODE_RSVD    = 3'd5,
    MODE_FTEST   = 3'd6,
    MODE_CONFIG  = 3'd7
  } ecp_mode_e;

  localparam logic [1:0] ST_SOME  = 2'b00;
  localparam logic [1:0] ST_EMPTY = 2'b01;
  localparam logic [1:0] ST_FULL  = 2'b10;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CFGB = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
endpackage

// File: rtl/ecp_rst_sync.sv
module ecp_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ecp_mode_reg.sv
module ecp_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [5:0] din,      // written byte bits 7:2
  output logic [2:0] mode,
  output logic [2:0] spare,
  output logic       changing
);
  import ecp_pkg::*;

  logic [2:0] mode_q, mode_d;
  logic [2:0] spare_q, spare_d;

  always_comb begin
    mode_d  = mode_q;
    spare_d = spare_q;
    if (wr) begin
      mode_d  = din[5:3];
      spare_d = din[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_COMPAT;
      spare_q <= 3'b000;
    end else begin
      mode_q  <= mode_d;
      spare_q <= spare_d;
    end
  end

  assign mode     = mode_q;
  assign spare    = spare_q;
  assign changing = wr && (din[5:3] != mode_q);
endmodule

// File: rtl/ecp_xfifo.sv
module ecp_xfifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        status
);
  import ecp_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [1:0]        status_q, status_d;

  logic [CNT_W-1:0]  wr_inc, rd_inc;
  logic              wr_wrap, rd_wrap;
  logic [PTR_W-1:0]  rd_next;
  logic              push_ok, pop_ok;

  assign wr_inc  = {1'b0, wr_ptr_q} + 1'b1;
  assign rd_inc  = {1'b0, rd_ptr_q} + 1'b1;
  assign wr_wrap = (wr_inc == DEPTH_C);
  assign rd_wrap = (rd_inc == DEPTH_C);
  assign rd_next = rd_wrap ? '0 : rd_inc[PTR_W-1:0];
  assign push_ok = push && !flush && (status_q != ST_FULL);
  assign pop_ok  = pop && !push && !flush && (status_q != ST_EMPTY);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    status_d = status_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      status_d = ST_EMPTY;
    end else if (push_ok) begin
      wr_ptr_d = wr_wrap ? '0 : wr_inc[PTR_W-1:0];
      status_d = wr_wrap ? ST_FULL : ST_SOME;
    end else if (pop_ok) begin
      rd_ptr_d = rd_next;
      status_d = (rd_next == wr_ptr_q) ? ST_EMPTY : ST_SOME;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      status_q <= ST_EMPTY;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      status_q <= status_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic en;
    assign en = push_ok && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (en) mem_q[i] <= din;
    end
  end

  assign dout   = mem_q[rd_ptr_q];
  assign status = status_q;
endmodule

// File: rtl/ecp_ext_ctrl.sv
module ecp_ext_ctrl #(
  parameter int FIFO_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  import ecp_pkg::*;

  logic             rst_n_int;
  logic [2:0]       mode, spare;
  logic             mode_chg;
  logic [1:0]       fifo_st;
  logic [BYTE_W-1:0] fifo_dout;
  logic [BYTE_W-1:0] cfga_q, cfga_d, cfgb_q, cfgb_d;
  logic [BYTE_W-1:0] ctrl_val;
  logic             test_mode, hit_data, hit_cfgb, hit_ctrl;
  logic             push, pop, cfga_wr, cfgb_wr, ctrl_wr;

  ecp_rst_sync u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  assign test_mode = (mode == MODE_FTEST);
  assign hit_data  = (addr == OFS_DATA);
  assign hit_cfgb  = (addr == OFS_CFGB);
  assign hit_ctrl  = (addr == OFS_CTRL);
  assign push      = wr_en && hit_data && test_mode;
  assign pop       = rd_en && !wr_en && hit_data && test_mode;
  assign cfga_wr   = wr_en && hit_data && !test_mode;
  assign cfgb_wr   = wr_en && hit_cfgb;
  assign ctrl_wr   = wr_en && hit_ctrl;

  ecp_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n_int), .wr(ctrl_wr), .din(wdata[7:2]),
    .mode(mode), .spare(spare), .changing(mode_chg)
  );

  ecp_xfifo #(.DATA_W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_int), .push(push), .pop(pop),
    .flush(mode_chg), .din(wdata), .dout(fifo_dout), .status(fifo_st)
  );

  always_comb begin
    cfga_d = cfga_q;
    cfgb_d = cfgb_q;
    if (cfga_wr) cfga_d = wdata;
    if (cfgb_wr) cfgb_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cfga_q <= '0;
      cfgb_q <= '0;
    end else begin
      cfga_q <= cfga_d;
      cfgb_q <= cfgb_d;
    end
  end

  assign ctrl_val = {mode, spare, fifo_st};

  always_comb begin
    unique case (addr)
      OFS_DATA: rdata = test_mode ? fifo_dout : cfga_q;
      OFS_CFGB: rdata = cfgb_q;
      OFS_CTRL: rdata = ctrl_val;
      default:  rdata = '1;
    endcase
  end
endmodule

// File: rtl/ecp_ext_ctrl_chk.sv
module ecp_ext_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [2:0] wmode,
  input logic [7:0] rdata,
  input logic [7:0] ctrl
);
  logic ctrl_wr, data_acc_test;
  assign ctrl_wr       = wr_en && (addr == 3'd2);
  assign data_acc_test = (addr == 3'd0) && (ctrl[7:5] == 3'b110);

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1:0] != 2'b11); // R2

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (wmode != ctrl[7:5]) |=> (ctrl[7:5] == $past(wmode)) && (ctrl[1:0] == 2'b01)); // R4

  AST_SAME_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (wmode == ctrl[7:5]) |=> ctrl[1:0] == $past(ctrl[1:0])); // R3

  AST_IDLE_OUTSIDE_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:5] != 3'b110) && !ctrl_wr |=> $stable(ctrl[1:0])); // R9

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && data_acc_test && (ctrl[1:0] == 2'b10) |=> ctrl[1:0] == 2'b10); // R7

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && data_acc_test && (ctrl[1:0] == 2'b01) |=> ctrl[1:0] == 2'b01); // R8

  AST_HIGH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 3'd3) |-> rdata == 8'hFF); // R11
endmodule

bind ecp_ext_ctrl ecp_ext_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wmode(wdata[7:5]), .rdata(rdata), .ctrl(ctrl_val)
);

// File: tb/sim_ecp_ext_ctrl.sv
module sim_ecp_ext_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_ext_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b0; addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s offset %0d: actual %02h expected %02h", req, a, rdata, exp);
    end
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(3'd2, 8'h01, "R1");
    bus_rd(3'd0, 8'h00, "R1");
    bus_rd(3'd1, 8'h00, "R1");
  endtask

  task automatic t_cfg_regs;
    bus_wr(3'd0, 8'hA5);
    bus_rd(3'd0, 8'hA5, "R9");
    bus_rd(3'd2, 8'h01, "R9");
    bus_wr(3'd1, 8'h3C);
    bus_rd(3'd1, 8'h3C, "R10");
  endtask

  task automatic t_high_offsets;
    bus_wr(3'd5, 8'h12);
    bus_wr(3'd3, 8'h00);
    for (int i = 3; i < 8; i++) bus_rd(3'(i), 8'hFF, "R11");
    bus_rd(3'd0, 8'hA5, "R11");
    bus_rd(3'd1, 8'h3C, "R11");
    bus_rd(3'd2, 8'h01, "R11");
  endtask

  task automatic t_fill_drain;
    bus_wr(3'd2, 8'hDF);              // mode 110, bits4:2=111, status bits ignored
    bus_rd(3'd2, 8'hDD, "R3");
    bus_wr(3'd0, 8'h11);
    bus_rd(3'd2, 8'hDC, "R5");
    bus_wr(3'd0, 8'h22);
    bus_rd(3'd2, 8'hDE, "R5");
    bus_wr(3'd0, 8'h33);              // dropped
    bus_rd(3'd2, 8'hDE, "R7");
    bus_rd(3'd0, 8'h11, "R6");
    bus_rd(3'd2, 8'hDC, "R6");
    bus_rd(3'd0, 8'h22, "R7");        // 0x33 must not have overwritten
    bus_rd(3'd2, 8'hDD, "R6");
    bus_rd(3'd0, 8'h11, "R8");
    bus_rd(3'd0, 8'h11, "R8");
    bus_rd(3'd2, 8'hDD, "R8");
  endtask

  task automatic t_mode_change;
    bus_wr(3'd0, 8'h44);              // entry 0, wr ptr -> 1
    bus_wr(3'd2, 8'hC0);              // same mode: no flush
    bus_rd(3'd2, 8'hC0, "R3");
    bus_rd(3'd0, 8'h44, "R3");
    bus_rd(3'd2, 8'hC1, "R6");
    bus_wr(3'd0, 8'h55);              // entry 1, wraps -> full
    bus_rd(3'd2, 8'hC2, "R5");
    bus_wr(3'd2, 8'h20);              // mode 001: flush
    bus_rd(3'd2, 8'h21, "R4");
    bus_rd(3'd0, 8'hA5, "R9");
    bus_wr(3'd0, 8'h77);
    bus_rd(3'd0, 8'h77, "R9");
    bus_rd(3'd2, 8'h21, "R9");
    bus_wr(3'd2, 8'hC0);              // back to test mode
    bus_rd(3'd2, 8'hC1, "R4");
    bus_rd(3'd0, 8'h44, "R4");        // read ptr rewound to entry 0
  endtask

  task automatic t_rw_same_cycle;
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 3'd0; wdata = 8'h66;
    @(posedge clk); #1 wr_en = 1'b0; rd_en = 1'b0;
    bus_rd(3'd2, 8'hC0, "R12");
    bus_rd(3'd0, 8'h66, "R12");
    bus_rd(3'd2, 8'hC1, "R12");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cfg_regs();
    t_high_offsets();
    t_fill_drain();
    t_mode_change();
    t_rw_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule